// File: doc/BRIEF.md
# Clause-22 Management Frame Controller

This block runs single clause-22 management transactions towards a PHY. Software hands it one 32-bit word that already holds every field of the frame, and the block sends it bit for bit after a preamble. The clock pin is derived from the system clock. The data pin is split into an output, an output enable and an input, so a pad cell can build the tri-state line.

A transaction starts only when the word is written while the port enable is high. The idle flag goes low for the duration of the transaction. For a read, the block releases the data line at the second turnaround bit. It shifts in the sixteen bits the PHY returns and places them in the low half of the stored word once the frame ends. The divide select keeps the management clock slow enough for the attached PHY. Software picks a larger divide for a faster system clock.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, idle_o is 1, mdc_o is 0, mdio_oe_o is 0 and frame_rdata_o is 0.
- R2: With port_en_i high, mdc_o toggles every 4<<div_sel_i system clocks, which gives a total divide of 8, 16, 32 or 64 for div_sel_i 0 to 3. With port_en_i low, mdc_o is held at 0.
- R3: A transaction drives 32 preamble ones, then frame bits 31 down to 0. Each new bit is driven at a falling edge of mdc_o, and mdio_o and mdio_oe_o change only at such edges.
- R4: The frame layout is: bits 31:30 start, 29:28 operation (01 write, 10 read), 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data. For a read, mdio_oe_o drops from frame bit 16 to the end of the frame. For a write, mdio_oe_o stays high for all 64 bits.
- R5: For a read, mdio_i is sampled at the rising edges of mdc_o during frame bits 15 down to 0, MSB first. The sampled value replaces bits 15:0 of frame_rdata_o at completion, and bits 31:16 keep the written value.
- R6: idle_o is 0 from the cycle after an accepted write until the first falling edge of mdc_o after the last bit. At that edge mdio_oe_o drops and idle_o returns to 1.
- R7: A write while port_en_i is low stores the word in frame_rdata_o but starts no transaction.
- R8: A write while a transaction is running is ignored. frame_rdata_o is unchanged and the running frame continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Management port enable |
| div_sel_i | input | 2 | Clock divide select (8/16/32/64) |
| frame_we_i | input | 1 | Frame register write strobe |
| frame_wdata_i | input | 32 | Frame word to write |
| frame_rdata_o | output | 32 | Frame register readback |
| idle_o | output | 1 | 1 when no transaction is running |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that port_en_i and div_sel_i stay constant while a transaction runs. They also assume the PHY drives mdio_i only while the line is released. The stimulus changes enable and divide select only after idle_o has returned to 1. The bench's PHY model drives response bits only after the block has released the line, and holds mdio_i high otherwise. Writes during a transaction are issued well inside the frame, so they never coincide with the completing edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic {S_IDLE, S_RUN} eng_state_e;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SEL_W     = 2,
  parameter int BASE_HALF = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic [CNT_W:0]   half_m1;
  logic             wrap;

  assign half_m1 = ((CNT_W+1)'(BASE_HALF) << sel_i) - (CNT_W+1)'(1);
  assign wrap    = en_i && ({1'b0, cnt_q} >= half_m1);
  assign rise_o  = wrap && !mdc_q;
  assign fall_o  = wrap && mdc_q;
  assign mdc_o   = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_mdc_rise_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $past(en_i));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               we_i,
  input  logic [FRAME_W-1:0] wdata_i,
  input  logic               mdc_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               idle_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  localparam int TOTAL  = PRE_LEN + FRAME_W;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam int OP_LO  = FRAME_W - 4;
  // index of the second turnaround bit and of the first data bit
  localparam logic [CNT_W-1:0] REL_IDX  = CNT_W'(PRE_LEN + FRAME_W - 1 - DATA_W);
  localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(PRE_LEN + FRAME_W - DATA_W);
  localparam logic [CNT_W-1:0] TOTAL_C  = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] PRE_C    = CNT_W'(PRE_LEN);

  eng_state_e         state_q;
  logic [FRAME_W-1:0] frame_q, sh_q;
  logic [DATA_W-1:0]  cap_q;
  logic [CNT_W-1:0]   bit_n_q;
  logic               rd_q, mdio_q, oe_q;
  logic               next_bit, in_frame;

  assign in_frame = bit_n_q >= PRE_C;
  assign next_bit = in_frame ? sh_q[FRAME_W-1] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      frame_q <= '0;
      sh_q    <= '0;
      cap_q   <= '0;
      bit_n_q <= '0;
      rd_q    <= 1'b0;
      mdio_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (we_i) begin
            frame_q <= wdata_i;
            if (en_i) begin
              state_q <= S_RUN;
              sh_q    <= wdata_i;
              bit_n_q <= '0;
              rd_q    <= (wdata_i[OP_LO+1:OP_LO] == OP_RD);
            end
          end
        end
        S_RUN: begin
          if (fall_i) begin
            if (bit_n_q < TOTAL_C) begin
              mdio_q  <= next_bit;
              oe_q    <= !(rd_q && bit_n_q >= REL_IDX);
              bit_n_q <= bit_n_q + 1'b1;
              if (in_frame) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
            end else begin
              mdio_q  <= 1'b1;
              oe_q    <= 1'b0;
              state_q <= S_IDLE;
              if (rd_q) frame_q[DATA_W-1:0] <= cap_q;
            end
          end
          if (rise_i && rd_q && bit_n_q > DATA_IDX)
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign frame_o   = frame_q;
  assign idle_o    = (state_q == S_IDLE);
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;

  assert_oe_moves_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> $fell(mdc_i));
  assert_dout_moves_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_i));
  assert_read_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && rd_q && bit_n_q > REL_IDX) |-> !mdio_oe_o);
  assert_idle_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mdio_oe_o);
  assert_busy_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && we_i && !(fall_i && bit_n_q == TOTAL_C)) |=> $stable(frame_o));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int FRAME_W   = 32,
  parameter int PRE_LEN   = 32,
  parameter int DATA_W    = 16,
  parameter int SEL_W     = 2,
  parameter int BASE_HALF = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               port_en_i,
  input  logic [SEL_W-1:0]   div_sel_i,
  input  logic               frame_we_i,
  input  logic [FRAME_W-1:0] frame_wdata_i,
  output logic [FRAME_W-1:0] frame_rdata_o,
  output logic               idle_o,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  input  logic               mdio_i
);
  logic mdc, rise, fall;

  mdio_mdc_gen #(.SEL_W(SEL_W), .BASE_HALF(BASE_HALF)) u_mdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (port_en_i),
    .sel_i (div_sel_i),
    .mdc_o (mdc),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_engine #(.FRAME_W(FRAME_W), .PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (port_en_i),
    .we_i     (frame_we_i),
    .wdata_i  (frame_wdata_i),
    .mdc_i    (mdc),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .frame_o  (frame_rdata_o),
    .idle_o   (idle_o),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  assign mdc_o = mdc;
endmodule

// File: tb/tb_mdio_frame_ctrl.sv
module tb_mdio_frame_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        idle, mdc, mdio_out, mdio_oe;
  logic        mdio_phy = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .div_sel_i(div_sel),
    .frame_we_i(we), .frame_wdata_i(wdata), .frame_rdata_o(rdata),
    .idle_o(idle), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_phy)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_cnt, m_sent;
  bit          m_mdc, m_busy, m_rd, e_mdio, e_oe;
  bit          m_q[$];
  logic [31:0] m_frame;
  logic [15:0] m_cap;
  logic [15:0] resp = 16'h0000;

  always @(posedge clk) begin
    bit rise, fall, b, pn;
    int half;
    rise = 0; fall = 0;
    if (!rst_n) begin
      m_cnt = 0; m_mdc = 0; m_busy = 0; m_rd = 0; m_sent = 0;
      m_frame = '0; m_cap = '0; e_mdio = 1; e_oe = 0; m_q.delete();
      mdio_phy <= 1'b1;
    end else begin
      half = 4 << div_sel;
      if (!port_en) begin m_cnt = 0; m_mdc = 0; end
      else if (m_cnt >= half - 1) begin
        m_cnt = 0;
        if (m_mdc) fall = 1; else rise = 1;
        m_mdc = !m_mdc;
      end else m_cnt++;
      if (!m_busy) begin
        if (we) begin
          m_frame = wdata;
          if (port_en) begin
            m_busy = 1; m_sent = 0; m_rd = (wdata[29:28] == 2'b10);
            m_q.delete();
            for (int i = 0; i < 32; i++) m_q.push_back(1'b1);
            for (int i = 31; i >= 0; i--) m_q.push_back(wdata[i]);
          end
        end
      end else begin
        if (fall) begin
          if (m_q.size() > 0) begin
            b = m_q.pop_front();
            e_mdio = b;
            e_oe = !(m_rd && m_sent >= 47);
            m_sent++;
          end else begin
            e_oe = 0; e_mdio = 1; m_busy = 0;
            if (m_rd) m_frame[15:0] = m_cap;
          end
        end
        if (rise && m_rd && m_sent >= 49) m_cap = {m_cap[14:0], mdio_phy};
      end
      pn = 1'b1;
      if (m_busy && m_rd && m_sent >= 49 && m_sent <= 64) pn = resp[64 - m_sent];
      mdio_phy <= pn;
    end
  end

  // ---------------- per-clock comparison and bit capture ----------------
  bit   prev_mdc = 0;
  bit   cap_on = 0;
  bit   got[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(mdc == m_mdc, "R2 mdc", {31'b0, mdc}, {31'b0, m_mdc});
      chk(mdio_oe == e_oe, "R4 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe) chk(mdio_out == e_mdio, "R3 mdio", {31'b0, mdio_out}, {31'b0, e_mdio});
      chk(idle == !m_busy, "R6 idle", {31'b0, idle}, {31'b0, !m_busy});
      chk(rdata == m_frame, "R5 rdata", rdata, m_frame);
      if (cap_on && mdc && !prev_mdc && mdio_oe) got.push_back(mdio_out);
    end
    prev_mdc = mdc;
  end

  // ---------------- stimulus ----------------
  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int k = 0;
    while (!idle && k < limit) begin @(negedge clk); k++; end
    chk(idle == 1'b1, "R6 completion", {31'b0, idle}, 32'd1);
  endtask

  task automatic run_frame(input logic [31:0] w, input logic [1:0] sel, input string req);
    bit exp_bits[$];
    int nb;
    bit ok;
    div_sel = sel;
    got.delete(); cap_on = 1;
    write_word(w);
    chk(idle == 1'b0, "R6 busy after write", {31'b0, idle}, 32'd0);
    wait_idle(20000);
    cap_on = 0;
    nb = (w[29:28] == 2'b10) ? 47 : 64;
    for (int i = 0; i < 32; i++) exp_bits.push_back(1'b1);
    for (int i = 31; i >= 0; i--) exp_bits.push_back(w[i]);
    chk(got.size() == nb, {req, " bit count"}, got.size(), nb);
    ok = 1;
    for (int i = 0; i < nb && i < got.size(); i++) if (got[i] != exp_bits[i]) ok = 0;
    chk(ok, {req, " bit stream"}, {31'b0, ok}, 32'd1);
  endtask

  initial begin
    logic [31:0] rw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(idle == 1'b1, "R1 idle", {31'b0, idle}, 32'd1);
    chk(mdc == 1'b0, "R1 mdc", {31'b0, mdc}, 32'd0);
    chk(mdio_oe == 1'b0, "R1 oe", {31'b0, mdio_oe}, 32'd0);
    chk(rdata == 32'd0, "R1 rdata", rdata, 32'd0);

    // R2: mdc held low with port disabled
    repeat (40) @(negedge clk);
    chk(mdc == 1'b0, "R2 mdc gated", {31'b0, mdc}, 32'd0);

    port_en = 1'b1;
    // R3/R4 write frame, divide 8
    run_frame({2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5C3}, 2'd0, "R3 write");
    chk(rdata == {2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5C3}, "R4 write keeps word",
        rdata, {2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5C3});

    // R5 read frame, divide 16, with an ignored write (R8) in the middle
    resp = 16'h3C96;
    rw = {2'b01, 2'b10, 5'd7, 5'd1, 2'b10, 16'h0000};
    div_sel = 2'd1;
    got.delete(); cap_on = 1;
    write_word(rw);
    repeat (200) @(negedge clk);
    write_word(32'hDEAD_BEEF);
    chk(rdata == rw, "R8 busy write ignored", rdata, rw);
    chk(idle == 1'b0, "R8 frame continues", {31'b0, idle}, 32'd0);
    wait_idle(20000);
    cap_on = 0;
    chk(got.size() == 47, "R4 read release count", got.size(), 47);
    chk(rdata == {rw[31:16], 16'h3C96}, "R5 read data", rdata, {rw[31:16], 16'h3C96});

    // R5 second read, divide 32, different pattern
    resp = 16'hF00D;
    rw = {2'b01, 2'b10, 5'd31, 5'd17, 2'b10, 16'h1234};
    run_frame(rw, 2'd2, "R4 read");
    chk(rdata == {rw[31:16], 16'hF00D}, "R5 read data 2", rdata, {rw[31:16], 16'hF00D});

    // R3 write, divide 64
    run_frame({2'b01, 2'b01, 5'd21, 5'd10, 2'b10, 16'h5AF0}, 2'd3, "R3 write div64");

    // R7 write with port disabled
    port_en = 1'b0;
    repeat (4) @(negedge clk);
    write_word(32'h5A5A_1111);
    repeat (60) @(negedge clk);
    chk(idle == 1'b1, "R7 no start", {31'b0, idle}, 32'd1);
    chk(mdio_oe == 1'b0, "R7 no drive", {31'b0, mdio_oe}, 32'd0);
    chk(mdc == 1'b0, "R7 mdc low", {31'b0, mdc}, 32'd0);
    chk(rdata == 32'h5A5A_1111, "R7 stored", rdata, 32'h5A5A_1111);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule